// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port with Pull-Ups and Key Wake

This block is one general-purpose I/O port of a small controller. Software reaches three registers over a simple register bus. The data latch holds the value to drive. The direction register chooses, bit by bit, whether each pin drives or only listens. The pull-up register turns on weak pull-ups, and each of its bits can cover a group of neighbouring pins. Every pin is brought out as separate output, output-enable and pull-up-enable signals, together with an input that comes back from the pad.

Pin inputs pass through a two-stage synchronizer. Reading the data register then gives a mixed view: output bits return the latch, and input bits return the synchronized pin level. The block also watches the AND of the levels on its input-configured pins. A falling edge of that AND raises a one-cycle key-wake request. Pins configured as outputs count as logic 1 in that AND, so they can never hide or create an event. A per-bit override lets another peripheral take over the drive value and the output enable of a pin.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch, the direction register and the pull-up register are all zero. pin_oe, pin_out and pin_pu are all zero, and key_irq is low.
- R2: Bus address 1 is the direction register. A 1 in bit i drives pin i (pin_oe[i]=1, pin_out[i]=latch[i]), and a 0 leaves pin i undriven. A write shows on the pins in the cycle after the write edge.
- R3: Bus address 0 is the data latch. A write to it updates every latch bit, including bits configured as input, and leaves pin_oe unchanged. Input bits stay undriven until their direction bit is set, and then they drive the value written earlier.
- R4: A read of address 0 returns, for each bit, latch[i] if direction[i]=1 and the synchronized pin level otherwise. A pin level must be stable for two clock edges before it can be read. bus_rdata is registered and is valid after the edge on which bus_rd is sampled.
- R5: Reads of address 1 and address 2 return the stored values. The pull-up register holds WIDTH/PU_GROUP bits, and its unused upper read bits are zero.
- R6: pin_pu[i] is 1 exactly when pull-up bit i/PU_GROUP is set and pin i is not driven. A driven pin ignores its pull-up bit.
- R7: When the AND of the input-configured synchronized pins falls from 1 to 0, key_irq goes high for exactly one cycle. It goes high on the third clock edge after the pin change. A rising AND raises nothing.
- R8: Pins configured as output count as 1 in the key AND. A level change on such a pin raises no key_irq.
- R9: When alt_en[i]=1, pin_out[i] and pin_oe[i] come from alt_out[i] and alt_oe[i] with no register delay, and the pull-up rule of R6 follows the overridden enable.
- R10: Writes to bus address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Level sensed at each pad |
| pin_out | output | WIDTH | Value driven to each pad |
| pin_oe | output | WIDTH | Pad drive enable per bit |
| pin_pu | output | WIDTH | Pad pull-up enable per bit |
| alt_en | input | WIDTH | Per-bit peripheral override select |
| alt_out | input | WIDTH | Peripheral drive value |
| alt_oe | input | WIDTH | Peripheral drive enable |
| key_irq | output | 1 | One-cycle key-wake request |

## Verification
Register writes reach pin_oe, pin_out and pin_pu one edge after the write, and the bench samples these signals on the falling edge that follows. The override inputs reach the pads with no register, so the bench checks them a moment after it changes them. Read data is due on the edge that samples bus_rd: the monitor records that edge and compares bus_rdata on the next falling edge. Before it reads back a pin, the bench holds the new level for three edges so that the synchronizer has settled. For key_irq it counts three edges from the pin change and checks both the high cycle and the low cycle that follows.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        RA_DATA  = 2'd0,
        RA_DIR   = 2'd1,
        RA_PULL  = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s1 <= '1;
            st_q.s2 <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.s2;

    // R4: the synchronized output only takes a value that stood in the first stage
    p_sync_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_out == $past(st_q.s1));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int PB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  latch,
    output logic [W-1:0]  dir,
    output logic [PB-1:0] pull,
    output logic [W-1:0]  rdata
);
    typedef struct packed {
        logic [W-1:0]  latch;
        logic [W-1:0]  dir;
        logic [PB-1:0] pull;
        logic [W-1:0]  rdata;
    } regs_t;

    regs_t rg_d, rg_q;
    reg_addr_e sel;
    logic [W-1:0] pull_wide;

    always_comb begin
        sel = reg_addr_e'(addr);
        pull_wide = '0;
        pull_wide[PB-1:0] = rg_q.pull;
        rg_d = rg_q;
        if (wr) begin
            unique case (sel)
                RA_DATA:  rg_d.latch = wdata;
                RA_DIR:   rg_d.dir   = wdata;
                RA_PULL:  rg_d.pull  = wdata[PB-1:0];
                default:  ;
            endcase
        end
        if (rd) begin
            unique case (sel)
                RA_DATA:  rg_d.rdata = (rg_q.latch & rg_q.dir) | (pin_sync & ~rg_q.dir);
                RA_DIR:   rg_d.rdata = rg_q.dir;
                RA_PULL:  rg_d.rdata = pull_wide;
                default:  rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign latch = rg_q.latch;
    assign dir   = rg_q.dir;
    assign pull  = rg_q.pull;
    assign rdata = rg_q.rdata;

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd1) |=> dir == $past(wdata));

    p_data_keeps_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0) |=> $stable(dir) && latch == $past(wdata));

    p_spare_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd3) |=> $stable(dir) && $stable(latch) && $stable(pull));
endmodule

// File: rtl/gpio_keywake.sv
module gpio_keywake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] dir,
    output logic         key_irq
);
    typedef struct packed {
        logic all_hi;
        logic irq;
    } kw_t;

    kw_t kw_d, kw_q;
    logic and_now;

    always_comb begin
        and_now     = &(pin_sync | dir);
        kw_d        = kw_q;
        kw_d.all_hi = and_now;
        kw_d.irq    = kw_q.all_hi & ~and_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kw_q.all_hi <= 1'b1;
            kw_q.irq    <= 1'b0;
        end else begin
            kw_q <= kw_d;
        end
    end

    assign key_irq = kw_q.irq;

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |=> !key_irq);

    p_irq_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> !kw_q.all_hi);
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int WIDTH    = 8,
    parameter int PU_GROUP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic             key_irq
);
    localparam int PU_BITS = WIDTH / PU_GROUP;

    logic [WIDTH-1:0]   pin_sync;
    logic [WIDTH-1:0]   latch;
    logic [WIDTH-1:0]   dir;
    logic [PU_BITS-1:0] pull;

    gpio_sync #(.W(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.W(WIDTH), .PB(PU_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .latch    (latch),
        .dir      (dir),
        .pull     (pull),
        .rdata    (bus_rdata)
    );

    gpio_keywake #(.W(WIDTH)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .dir      (dir),
        .key_irq  (key_irq)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
        always_comb begin
            pin_out[i] = alt_en[i] ? alt_out[i] : latch[i];
            pin_oe[i]  = alt_en[i] ? alt_oe[i]  : dir[i];
            pin_pu[i]  = pull[i / PU_GROUP] & ~pin_oe[i];
        end
    end

    p_pu_off_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_pu) == '0);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe & ~alt_en) == '0 && !key_irq);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [7:0] pin_in = 8'hFF, pin_out, pin_oe, pin_pu;
    logic [7:0] alt_en = 8'h00, alt_out = 8'h00, alt_oe = 8'h00;
    logic       key_irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } item_t;
    item_t exp_q[$];
    logic  rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe), .key_irq(key_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compares read data on the falling edge after the sampling edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard underflow actual %02h expected none", bus_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.tag = tag; it.exp = e;
        exp_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 pin_pu", pin_pu, 8'h00);
        check("R1 key_irq", {7'd0, key_irq}, 8'h00);
        bus_read(2'd1, 8'h00, "R1 dir read");
        bus_read(2'd0, 8'hFF, "R4 all inputs high");

        bus_write(2'd1, 8'h0F);
        check("R2 pin_oe", pin_oe, 8'h0F);
        check("R2 pin_out", pin_out, 8'h00);

        bus_write(2'd0, 8'hA5);
        check("R3 oe unchanged", pin_oe, 8'h0F);
        check("R2 drive latch", pin_out & pin_oe, 8'h05);

        pin_in = 8'h3C;
        idle(4);
        bus_read(2'd0, 8'h35, "R4 mixed read");
        pin_in = 8'hFF;
        idle(5);

        // R8: falling level on an output-configured pin
        pin_in = 8'hFB;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (key_irq) seen++;
        end
        check("R8 no irq from output pin", seen[7:0], 8'h00);

        // R7: falling level on an input pin
        pin_in = 8'hBB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 irq high", {7'd0, key_irq}, 8'h01);
        @(negedge clk);
        check("R7 irq one cycle", {7'd0, key_irq}, 8'h00);
        pin_in = 8'hFF;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (key_irq) seen++;
        end
        check("R7 no irq on rise", seen[7:0], 8'h00);

        bus_write(2'd2, 8'h05);
        check("R6 pull on inputs only", pin_pu, 8'h30);
        bus_read(2'd2, 8'h05, "R5 pull read");
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, 8'h0F, "R5 pull upper zero");
        check("R6 pull all inputs", pin_pu, 8'hF0);

        bus_write(2'd3, 8'h00);
        bus_read(2'd1, 8'h0F, "R10 dir kept");
        bus_read(2'd2, 8'h0F, "R10 pull kept");
        bus_write(2'd1, 8'hFF);
        check("R6 pull off when driven", pin_pu, 8'h00);
        bus_read(2'd0, 8'hA5, "R3 latch held while input");
        check("R3 drives earlier write", pin_out, 8'hA5);

        @(negedge clk);
        alt_en = 8'h81; alt_out = 8'h80; alt_oe = 8'h01;
        #1;
        check("R9 pin_out", pin_out, 8'hA4);
        check("R9 pin_oe", pin_oe, 8'h7F);
        check("R9 pull follows oe", pin_pu, 8'h80);

        idle(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule